// File: doc/BRIEF.md
# OLED Row Timing Sequencer

This block produces the row-rate control waveforms for an active-matrix OLED panel whose pixels are calibrated before they are written. A frame-start pulse arms the sequencer, and each row strobe then opens one row period. A free-running phase counter splits that period into a calibration phase and a data phase. Every pulse edge is a position in clock cycles inside the period, and every position is a parameter.

Each panel row is selected twice. The first select loads zero data. This turns the pixel off so that the diode capacitance can drain before calibration. The second select comes one row period later and writes the real data. In any row period the current row is calibrated and programmed while the following row is blanked. Adjacent rows have opposite parity, so the select, calibrate and calibrate-bar lines come in an odd set and an even set. The set whose parity matches the current row carries the programming pattern, and the other set carries the blanking pattern.

The block also drives three column demultiplexer strobes and a start bit and shift clock for the row scanner.

Top module: `oled_row_seq`

## Requirements
- R1: After reset, and until a row period has begun, every output is idle: all select, calibrate and data strobes are 0, both calibrate-bar outputs are 1, and the scan start and shift clock are 0.
- R2: Before any frame-start pulse has been seen, a row strobe has no effect and the outputs stay idle.
- R3: The first row strobe after a frame-start pulse opens the period of row 1. Scan start is 1 for every position of that period and is 0 in every other period.
- R4: Each later row strobe advances the row by one. After row NUM_ROWS the sequence continues at row 1, and scan start stays 0.
- R5: Row parity is bit 0 of the row number. For an odd row the odd set (sel_odd, az_odd, azb_odd) is the programming set and the even set is the blanking set. For an even row the roles are swapped.
- R6: In the programming set, select is 1 at positions [SEL_ON, SEL_OFF). Calibrate is 1 at [AZ_ON, AZ_OFF). Calibrate-bar is 0 at [AZB_ON, AZB_OFF). All three windows lie in the calibration phase (positions 0 to AZ_CYC-1) or, for select, span both phases.
- R7: In the blanking set, select is 1 at data-phase positions [AZ_CYC+BLK_ON, AZ_CYC+BLK_OFF). Its calibrate output stays 0 and its calibrate-bar output stays 1.
- R8: The data strobes fire in the data phase in the order reset, odd, even. Reset is 1 at [AZ_CYC+DRST_ON, AZ_CYC+DRST_OFF), odd at [AZ_CYC+DODD_ON, AZ_CYC+DODD_OFF), and even at [AZ_CYC+DEVN_ON, AZ_CYC+DEVN_OFF). No two are ever 1 together.
- R9: The shift clock is 1 at positions [0, SCK_HI) of every row period.
- R10: A row strobe sampled on clock edge E makes the outputs for position 0 appear after edge E+1. Position p appears after edge E+1+p.
- R11: When AZ_CYC+DATA_CYC positions have elapsed with no new row strobe, the outputs return to idle.
- R12: A row strobe that arrives inside a period ends that period and starts the next row at position 0.
- R13: A frame-start pulse inside a period does not change the rest of that period. The next row strobe restarts at row 1 with scan start set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_start | input | 1 | Arms a restart at row 1 |
| row_strobe | input | 1 | Opens a new row period |
| sel_odd | output | 1 | Select for odd rows |
| sel_even | output | 1 | Select for even rows |
| az_odd | output | 1 | Calibrate for odd rows |
| az_even | output | 1 | Calibrate for even rows |
| azb_odd | output | 1 | Calibrate-bar for odd rows (active low) |
| azb_even | output | 1 | Calibrate-bar for even rows (active low) |
| data_rst | output | 1 | Column zero-data strobe |
| data_odd | output | 1 | Odd-column data strobe |
| data_even | output | 1 | Even-column data strobe |
| scan_start | output | 1 | Start bit for the row scanner |
| shift_clk | output | 1 | Shift clock for the row scanner |

## Verification
Two situations are hard to reach from the ports. The first is the wrap from the last row back to row 1 without a new scan start. The second is a frame-start pulse that lands in the middle of a period. The bench reaches both by building the sequencer with only four rows and short phases. It then runs a complete frame plus two extra rows and compares every output against an arithmetic model on every cycle. In a later period it raises frame-start partway through, checks that the rest of that period is unchanged, and checks that the next strobe restarts at row 1 with the start bit set. A strobe sent mid-period and a strobe sent before any frame start cover the restart and ignore paths.

// File: rtl/oled_seq_pkg.sv
package oled_seq_pkg;

  // Position p lies in the half-open window [lo, hi).
  function automatic logic in_win(input int unsigned p, input int unsigned lo,
                                  input int unsigned hi);
    return (p >= lo) && (p < hi);
  endfunction

  // Index of each set in the per-parity vectors.
  localparam int unsigned SET_EVEN = 0;
  localparam int unsigned SET_ODD  = 1;

endpackage

// File: rtl/oled_phase_ctr.sv
module oled_phase_ctr #(
  parameter int unsigned ROW_CYC = 3962,
  localparam int unsigned PW = $clog2(ROW_CYC + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  output logic [PW-1:0] pos,
  output logic          live
);

  localparam logic [PW-1:0] IDLE_POS = PW'(ROW_CYC);

  logic [PW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign live   = (cnt_q != IDLE_POS);
  assign cnt_en = restart || live;

  always_comb begin
    if (restart) cnt_d = '0;
    else         cnt_d = cnt_q + PW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= IDLE_POS;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign pos = cnt_q;

endmodule

// File: rtl/oled_row_track.sv
module oled_row_track #(
  parameter int unsigned NUM_ROWS = 240,
  localparam int unsigned RW = $clog2(NUM_ROWS + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic frame_start,
  input  logic row_strobe,
  output logic restart,
  output logic row_odd,
  output logic first
);

  logic          armed_q, armed_d, run_q, run_d, first_q, first_d;
  logic [RW-1:0] row_q, row_d;
  logic          armed_eff;

  assign armed_eff = armed_q || frame_start;
  assign restart   = row_strobe && (armed_eff || run_q);

  always_comb begin
    armed_d = armed_eff;
    run_d   = run_q;
    first_d = first_q;
    row_d   = row_q;
    if (row_strobe && armed_eff) begin
      armed_d = 1'b0;
      run_d   = 1'b1;
      first_d = 1'b1;
      row_d   = RW'(1);
    end else if (row_strobe && run_q) begin
      first_d = 1'b0;
      row_d   = (row_q == RW'(NUM_ROWS)) ? RW'(1) : row_q + RW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      run_q   <= 1'b0;
      first_q <= 1'b0;
      row_q   <= RW'(1);
    end else begin
      armed_q <= armed_d;
      run_q   <= run_d;
      first_q <= first_d;
      row_q   <= row_d;
    end
  end

  assign row_odd = row_q[0];
  assign first   = first_q;

endmodule

// File: rtl/oled_wave_gen.sv
module oled_wave_gen
  import oled_seq_pkg::*;
#(
  parameter int unsigned PW        = 12,
  parameter int unsigned SEL_ON    = 100,
  parameter int unsigned SEL_OFF   = 3900,
  parameter int unsigned AZ_ON     = 200,
  parameter int unsigned AZ_OFF    = 1300,
  parameter int unsigned AZB_ON    = 150,
  parameter int unsigned AZB_OFF   = 1400,
  parameter int unsigned BLK_ON    = 1600,
  parameter int unsigned BLK_OFF   = 2000,
  parameter int unsigned DRST_ON   = 1600,
  parameter int unsigned DRST_OFF  = 2000,
  parameter int unsigned DODD_ON   = 2100,
  parameter int unsigned DODD_OFF  = 2900,
  parameter int unsigned DEVN_ON   = 3000,
  parameter int unsigned DEVN_OFF  = 3800,
  parameter int unsigned SCK_HI    = 1981
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [PW-1:0] pos,
  input  logic          live,
  input  logic          row_odd,
  input  logic          first,
  output logic [1:0]    sel,
  output logic [1:0]    az,
  output logic [1:0]    azb,
  output logic [2:0]    dstrb,
  output logic          scan_start,
  output logic          shift_clk
);

  int unsigned p;
  logic w_sel, w_az, w_azb, w_blk, w_sck;
  logic [1:0] sel_d, az_d, azb_d;
  logic [2:0] dstrb_d;
  logic       scan_d, sck_d;

  assign p     = 32'(pos);
  assign w_sel = in_win(p, SEL_ON, SEL_OFF);
  assign w_az  = in_win(p, AZ_ON, AZ_OFF);
  assign w_azb = in_win(p, AZB_ON, AZB_OFF);
  assign w_blk = in_win(p, BLK_ON, BLK_OFF);
  assign w_sck = in_win(p, 0, SCK_HI);

  for (genvar s = 0; s < 2; s++) begin : g_set
    logic prog_s, blank_s;
    assign prog_s   = live && (row_odd == (s == SET_ODD));
    assign blank_s  = live && (row_odd != (s == SET_ODD));
    assign sel_d[s] = (prog_s && w_sel) || (blank_s && w_blk);
    assign az_d[s]  = prog_s && w_az;
    assign azb_d[s] = !(prog_s && w_azb);
  end

  always_comb begin
    dstrb_d[0] = live && in_win(p, DRST_ON, DRST_OFF);
    dstrb_d[1] = live && in_win(p, DODD_ON, DODD_OFF);
    dstrb_d[2] = live && in_win(p, DEVN_ON, DEVN_OFF);
    scan_d     = live && first;
    sck_d      = live && w_sck;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel        <= '0;
      az         <= '0;
      azb        <= '1;
      dstrb      <= '0;
      scan_start <= 1'b0;
      shift_clk  <= 1'b0;
    end else begin
      sel        <= sel_d;
      az         <= az_d;
      azb        <= azb_d;
      dstrb      <= dstrb_d;
      scan_start <= scan_d;
      shift_clk  <= sck_d;
    end
  end

endmodule

// File: rtl/oled_row_seq.sv
module oled_row_seq #(
  parameter int unsigned NUM_ROWS = 240,
  parameter int unsigned AZ_CYC   = 1500,
  parameter int unsigned DATA_CYC = 2462,
  parameter int unsigned SEL_ON   = 100,
  parameter int unsigned SEL_OFF  = 3900,
  parameter int unsigned AZ_ON    = 200,
  parameter int unsigned AZ_OFF   = 1300,
  parameter int unsigned AZB_ON   = 150,
  parameter int unsigned AZB_OFF  = 1400,
  parameter int unsigned BLK_ON   = 100,
  parameter int unsigned BLK_OFF  = 500,
  parameter int unsigned DRST_ON  = 100,
  parameter int unsigned DRST_OFF = 500,
  parameter int unsigned DODD_ON  = 600,
  parameter int unsigned DODD_OFF = 1400,
  parameter int unsigned DEVN_ON  = 1500,
  parameter int unsigned DEVN_OFF = 2300,
  parameter int unsigned SCK_HI   = 1981
) (
  input  logic clk,
  input  logic rst_n,
  input  logic frame_start,
  input  logic row_strobe,
  output logic sel_odd,
  output logic sel_even,
  output logic az_odd,
  output logic az_even,
  output logic azb_odd,
  output logic azb_even,
  output logic data_rst,
  output logic data_odd,
  output logic data_even,
  output logic scan_start,
  output logic shift_clk
);

  localparam int unsigned ROW_CYC = AZ_CYC + DATA_CYC;
  localparam int unsigned PW      = $clog2(ROW_CYC + 1);

  logic          restart, row_odd, first, live;
  logic [PW-1:0] pos;
  logic [1:0]    sel, az, azb;
  logic [2:0]    dstrb;

  oled_row_track #(.NUM_ROWS(NUM_ROWS)) u_track (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .row_strobe(row_strobe),
    .restart(restart), .row_odd(row_odd), .first(first)
  );

  oled_phase_ctr #(.ROW_CYC(ROW_CYC)) u_ctr (
    .clk(clk), .rst_n(rst_n), .restart(restart), .pos(pos), .live(live)
  );

  oled_wave_gen #(
    .PW(PW),
    .SEL_ON(SEL_ON), .SEL_OFF(SEL_OFF),
    .AZ_ON(AZ_ON), .AZ_OFF(AZ_OFF),
    .AZB_ON(AZB_ON), .AZB_OFF(AZB_OFF),
    .BLK_ON(AZ_CYC + BLK_ON), .BLK_OFF(AZ_CYC + BLK_OFF),
    .DRST_ON(AZ_CYC + DRST_ON), .DRST_OFF(AZ_CYC + DRST_OFF),
    .DODD_ON(AZ_CYC + DODD_ON), .DODD_OFF(AZ_CYC + DODD_OFF),
    .DEVN_ON(AZ_CYC + DEVN_ON), .DEVN_OFF(AZ_CYC + DEVN_OFF),
    .SCK_HI(SCK_HI)
  ) u_wave (
    .clk(clk), .rst_n(rst_n), .pos(pos), .live(live), .row_odd(row_odd),
    .first(first), .sel(sel), .az(az), .azb(azb), .dstrb(dstrb),
    .scan_start(scan_start), .shift_clk(shift_clk)
  );

  assign sel_odd   = sel[1];
  assign sel_even  = sel[0];
  assign az_odd    = az[1];
  assign az_even   = az[0];
  assign azb_odd   = azb[1];
  assign azb_even  = azb[0];
  assign data_rst  = dstrb[0];
  assign data_odd  = dstrb[1];
  assign data_even = dstrb[2];

endmodule

// File: rtl/oled_row_seq_chk.sv
module oled_row_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic sel_odd,
  input logic sel_even,
  input logic az_odd,
  input logic az_even,
  input logic azb_odd,
  input logic azb_even,
  input logic data_rst,
  input logic data_odd,
  input logic data_even,
  input logic scan_start,
  input logic shift_clk
);

  // R8
  data_strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({data_rst, data_odd, data_even}) <= 1);

  // R5
  az_one_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(az_odd && az_even));

  // R6
  az_odd_in_azb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    az_odd |-> (!azb_odd && sel_odd));

  // R6
  az_even_in_azb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    az_even |-> (!azb_even && sel_even));

  // R7
  blank_no_az_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_odd && sel_even) |-> (!az_odd && !az_even));

  // R3
  start_with_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scan_start) |-> shift_clk);

endmodule

bind oled_row_seq oled_row_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sel_odd(sel_odd), .sel_even(sel_even),
  .az_odd(az_odd), .az_even(az_even), .azb_odd(azb_odd), .azb_even(azb_even),
  .data_rst(data_rst), .data_odd(data_odd), .data_even(data_even),
  .scan_start(scan_start), .shift_clk(shift_clk)
);

// File: tb/oled_row_seq_tb.sv
module oled_row_seq_tb;

  localparam int NR = 4;
  localparam int AZ = 6;
  localparam int DT = 12;
  localparam int RC = AZ + DT;
  localparam logic [10:0] IDLE = 11'b00_00_11_000_00;

  logic clk = 1'b0;
  logic rst_n, frame_start, row_strobe;
  logic sel_odd, sel_even, az_odd, az_even, azb_odd, azb_even;
  logic data_rst, data_odd, data_even, scan_start, shift_clk;

  int vecs = 0;
  int bad  = 0;
  string ctx = "R1";

  always #4 clk = ~clk;

  oled_row_seq #(
    .NUM_ROWS(NR), .AZ_CYC(AZ), .DATA_CYC(DT),
    .SEL_ON(1), .SEL_OFF(17), .AZ_ON(2), .AZ_OFF(5), .AZB_ON(1), .AZB_OFF(6),
    .BLK_ON(1), .BLK_OFF(4), .DRST_ON(1), .DRST_OFF(4),
    .DODD_ON(4), .DODD_OFF(8), .DEVN_ON(8), .DEVN_OFF(12), .SCK_HI(9)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .row_strobe(row_strobe),
    .sel_odd(sel_odd), .sel_even(sel_even), .az_odd(az_odd), .az_even(az_even),
    .azb_odd(azb_odd), .azb_even(azb_even), .data_rst(data_rst),
    .data_odd(data_odd), .data_even(data_even), .scan_start(scan_start),
    .shift_clk(shift_clk)
  );

  function automatic logic inw(int p, int lo, int hi);
    return (p >= lo) && (p < hi);
  endfunction

  // Bit order: sel_o sel_e az_o az_e azb_o azb_e drst dodd devn scan sck
  function automatic logic [10:0] expv(int row, bit first, int p);
    logic prog_sel, prog_az, prog_azbl, blk;
    logic [10:0] v;
    prog_sel  = inw(p, 1, 17);
    prog_az   = inw(p, 2, 5);
    prog_azbl = inw(p, 1, 6);
    blk       = inw(p, AZ + 1, AZ + 4);
    if (row % 2 == 1) begin
      v[10] = prog_sel; v[9] = blk;
      v[8]  = prog_az;  v[7] = 1'b0;
      v[6]  = !prog_azbl; v[5] = 1'b1;
    end else begin
      v[10] = blk; v[9] = prog_sel;
      v[8]  = 1'b0; v[7] = prog_az;
      v[6]  = 1'b1; v[5] = !prog_azbl;
    end
    v[4] = inw(p, AZ + 1, AZ + 4);
    v[3] = inw(p, AZ + 4, AZ + 8);
    v[2] = inw(p, AZ + 8, AZ + 12);
    v[1] = first;
    v[0] = inw(p, 0, 9);
    return v;
  endfunction

  function automatic string tag_of(int b, int row, bit idle);
    if (idle) return "R1";
    if (b >= 5) return (((b % 2) == 0) == (row % 2 == 1)) ? "R6" : "R7";
    if (b >= 2) return "R8";
    if (b == 1) return "R3";
    return "R9";
  endfunction

  task automatic compare(logic [10:0] e, int row, bit idle, int p);
    logic [10:0] a;
    bit miss = 0;
    a = {sel_odd, sel_even, az_odd, az_even, azb_odd, azb_even,
         data_rst, data_odd, data_even, scan_start, shift_clk};
    vecs++;
    for (int b = 0; b < 11; b++) begin
      if (a[b] !== e[b]) begin
        miss = 1;
        $display("FAIL %s (%s) row %0d pos %0d bit %0d: actual %b expected %b",
                 tag_of(b, row, idle), ctx, row, p, b, a[b], e[b]);
      end
    end
    if (miss) bad++;
  endtask

  task automatic check_idle(int n);
    for (int j = 0; j < n; j++) begin
      @(negedge clk);
      compare(IDLE, 0, 1'b1, -1);
    end
  endtask

  // Called at a negedge. Strobe is sampled at the next posedge (E).
  task automatic run_period(int row, bit first, int n, bit gap, int fs_at);
    row_strobe = 1'b1;
    @(negedge clk);
    row_strobe = 1'b0;
    if (gap) compare(IDLE, row, 1'b1, -1);  // R10: position 0 not yet visible
    for (int j = 0; j < n; j++) begin
      @(negedge clk);
      compare(expv(row, first, j), row, 1'b0, j);
      frame_start = (j == fs_at);
    end
    frame_start = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; frame_start = 1'b0; row_strobe = 1'b0;
    repeat (3) @(negedge clk);
    compare(IDLE, 0, 1'b1, -1);
    rst_n = 1'b1;
    ctx = "R1";
    check_idle(3);

    ctx = "R2";
    row_strobe = 1'b1;
    @(negedge clk);
    row_strobe = 1'b0;
    check_idle(RC + 2);

    frame_start = 1'b1;
    @(negedge clk);
    frame_start = 1'b0;

    ctx = "R3";
    run_period(1, 1'b1, RC, 1'b1, -1);
    ctx = "R5";
    run_period(2, 1'b0, RC, 1'b1, -1);
    ctx = "R10";
    run_period(3, 1'b0, RC, 1'b1, -1);
    ctx = "R4";
    run_period(4, 1'b0, RC, 1'b1, -1);
    run_period(1, 1'b0, RC, 1'b1, -1);
    run_period(2, 1'b0, RC, 1'b1, -1);

    ctx = "R11";
    check_idle(5);

    ctx = "R12";
    run_period(3, 1'b0, 7, 1'b1, -1);
    run_period(4, 1'b0, RC, 1'b0, -1);

    ctx = "R13";
    run_period(1, 1'b0, RC, 1'b1, 3);
    run_period(1, 1'b1, RC, 1'b1, -1);
    run_period(2, 1'b0, RC, 1'b1, -1);

    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end

endmodule